// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one programmable event counter for a processor core. On every cycle where the event source presents a sample, the sample carries three values: how many times the monitored event happened in that cycle, how many times it happened on the sibling hardware thread, and the privilege level the core was running at. A control word sets the counting mode. The counter can add the raw number of occurrences. It can also add one for each cycle that passes a threshold test, with an optional inversion. A third choice adds one only when such cycles begin, after a cycle that did not pass.

The result goes into a 48-bit count that software can read at any time and overwrite. When the count wraps past all-ones, a sticky overflow flag is set, and a write to the count clears it. The event input uses valid/ready. The block never applies back-pressure: `evt_ready` is always high, so a sample is taken on every cycle where `evt_valid` is high. A cycle with `evt_valid` low carries no sample and has no effect on the count or on the edge history.

Control word layout in `cfg_wdata`/`cfg_rdata`: bits [7:0] threshold, bit 8 user enable, bit 9 kernel enable, bit 10 invert, bit 11 edge, bit 12 any-thread, bit 13 global enable.

Top module: `pec_event_counter`

## Requirements
- R1: After reset the count, the overflow flag and the control word all read zero.
- R2: A sample is eligible only if its privilege level is enabled: level 0 needs the kernel enable bit 9, and levels 1, 2 and 3 need the user enable bit 8. A sample that is not eligible adds nothing and counts as a non-qualifying cycle.
- R3: When the threshold is 0 and edge (bit 11) is clear, an eligible sample adds its occurrence amount to the count, and invert (bit 10) has no effect.
- R4: When the threshold is nonzero, an eligible sample qualifies if its occurrence amount is greater than or equal to the threshold, and each qualifying sample adds one.
- R5: When the threshold is nonzero and invert is set, the result of the threshold test is complemented before it decides whether the sample qualifies.
- R6: When the threshold is nonzero and edge is set, a qualifying sample adds one only if the previous sample was non-qualifying. This history is reset to non-qualifying while the global enable is off and on every control write.
- R7: When edge is set and the threshold is 0, the configuration is invalid and the count does not change.
- R8: When any-thread (bit 12) is set, the occurrence amount is the sum of `evt_occ` and `sib_occ`. Otherwise it is `evt_occ` alone.
- R9: An increment that carries out of bit 47 wraps the count and sets `ovf`. `ovf` stays set until a count write clears it.
- R10: A count write loads `cnt_wdata` and clears `ovf`, taking priority over any increment in the same cycle.
- R11: No counting happens while the global enable (bit 13) is clear, on cycles with `evt_valid` low, or on a cycle with a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event sample present this cycle |
| evt_ready | output | 1 | Always 1: samples are never stalled |
| evt_occ | input | OCC_W | Occurrences of the event on this thread |
| sib_occ | input | OCC_W | Occurrences of the event on the sibling thread |
| priv_lvl | input | 2 | Privilege level of the sample |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 14 | Control word to write |
| cfg_rdata | output | 14 | Current control word |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count value to write |
| cnt_value | output | CNT_W | Current count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that a control word, once written, stays in place until the next control write. They also assume that every count write is visible one cycle later, with no other writer on the count. The stimulus follows this: control writes happen only at phase boundaries, and count writes are single-cycle pulses. Occurrence amounts and privilege levels are drawn at random over their full ranges. `evt_valid` drops at random so that the hold rule for edge history is exercised.

// File: rtl/pec_pkg.sv
package pec_pkg;
  parameter int THR_W = 8;

  // Control word; bit 13 down to bit 0
  typedef struct packed {
    logic             enable;
    logic             any_thr;
    logic             edge_det;
    logic             invert;
    logic             krn_en;
    logic             usr_en;
    logic [THR_W-1:0] thresh;
  } pec_cfg_t;

  localparam int CFG_W = $bits(pec_cfg_t);
endpackage

// File: rtl/pec_qualify.sv
module pec_qualify
  import pec_pkg::*;
#(
  parameter int OCC_W = 8
) (
  input  pec_cfg_t         cfg,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] sib,
  input  logic [1:0]       priv,
  output logic [OCC_W:0]   raw_amt,
  output logic             qual,
  output logic             raw_mode,
  output logic             bad_mode
);
  localparam int SUM_W = OCC_W + 1;

  logic             priv_ok;
  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] thr_ext;
  logic             meets;

  always_comb begin
    priv_ok  = (priv == 2'd0) ? cfg.krn_en : cfg.usr_en;
    total    = cfg.any_thr ? ({1'b0, occ} + {1'b0, sib}) : {1'b0, occ};
    thr_ext  = SUM_W'(cfg.thresh);
    meets    = (total >= thr_ext);
    qual     = priv_ok & (meets ^ cfg.invert);
    raw_amt  = priv_ok ? total : '0;
    raw_mode = (cfg.thresh == '0) & ~cfg.edge_det;
    bad_mode = (cfg.thresh == '0) &  cfg.edge_det;
  end
endmodule

// File: rtl/pec_edge.sv
module pec_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic qual,
  input  logic edge_en,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     prev_q <= 1'b0;
    else if (clear) prev_q <= 1'b0;
    else if (step)  prev_q <= qual;
  end

  assign pulse = step & qual & (~edge_en | ~prev_q);
endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int CNT_W = 48,
  parameter int INC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] value,
  output logic             ovf
);
  logic [CNT_W:0] nxt;

  assign nxt = {1'b0, value} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      ovf   <= 1'b0;
    end else if (wr_en) begin
      value <= wr_data;
      ovf   <= 1'b0;
    end else begin
      value <= nxt[CNT_W-1:0];
      if (nxt[CNT_W]) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pec_event_counter.sv
module pec_event_counter
  import pec_pkg::*;
#(
  parameter int OCC_W = 8,
  parameter int CNT_W = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_valid,
  output logic                     evt_ready,
  input  logic [OCC_W-1:0]         evt_occ,
  input  logic [OCC_W-1:0]         sib_occ,
  input  logic [1:0]               priv_lvl,
  input  logic                     cfg_we,
  input  logic [pec_pkg::CFG_W-1:0] cfg_wdata,
  output logic [pec_pkg::CFG_W-1:0] cfg_rdata,
  input  logic                     cnt_we,
  input  logic [CNT_W-1:0]         cnt_wdata,
  output logic [CNT_W-1:0]         cnt_value,
  output logic                     ovf
);
  localparam int INC_W = OCC_W + 1;

  pec_cfg_t         cfg_q;
  logic [INC_W-1:0] raw_amt;
  logic             qual, raw_mode, bad_mode;
  logic             active, step, pulse, hist_clr;
  logic [INC_W-1:0] inc;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= pec_cfg_t'(cfg_wdata);
  end

  assign cfg_rdata = cfg_q;
  assign evt_ready = 1'b1;

  pec_qualify #(.OCC_W(OCC_W)) u_qual (
    .cfg      (cfg_q),
    .occ      (evt_occ),
    .sib      (sib_occ),
    .priv     (priv_lvl),
    .raw_amt  (raw_amt),
    .qual     (qual),
    .raw_mode (raw_mode),
    .bad_mode (bad_mode)
  );

  assign active   = evt_valid & cfg_q.enable & ~cfg_we;
  assign step     = active & ~raw_mode & ~bad_mode;
  assign hist_clr = cfg_we | ~cfg_q.enable;

  pec_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (hist_clr),
    .step    (step),
    .qual    (qual),
    .edge_en (cfg_q.edge_det),
    .pulse   (pulse)
  );

  always_comb begin
    if (active && raw_mode) inc = raw_amt;
    else                    inc = INC_W'(pulse);
  end

  pec_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cnt_we),
    .wr_data (cnt_wdata),
    .inc     (inc),
    .value   (cnt_value),
    .ovf     (ovf)
  );
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int CNT_W = 48,
  parameter int CFG_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_value,
  input logic             ovf
);
  logic thr_zero;
  assign thr_zero = (cfg_rdata[7:0] == 8'd0);

  // R10
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_value == $past(cnt_wdata)) && !ovf);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cnt_we) |=> ovf);

  // R11
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[13] && !cnt_we) |=> $stable(cnt_value));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!evt_valid || cfg_we) && !cnt_we) |=> $stable(cnt_value));

  // R7
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[11] && thr_zero && !cnt_we) |=> $stable(cnt_value));

  // R6
  edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[11] && !cnt_we) |=>
      (cnt_value == $past(cnt_value)) || (cnt_value == $past(cnt_value) + 1'b1));
endmodule

bind pec_event_counter pec_checker #(.CNT_W(CNT_W), .CFG_W(pec_pkg::CFG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .cnt_we    (cnt_we),
  .cnt_wdata (cnt_wdata),
  .cnt_value (cnt_value),
  .ovf       (ovf)
);

// File: tb/sim_pec_event_counter.sv
`timescale 1ns/1ps
module sim_pec_event_counter;
  localparam int OCC_W = 8;
  localparam int CNT_W = 48;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             evt_valid = 1'b0;
  logic             evt_ready;
  logic [OCC_W-1:0] evt_occ = '0;
  logic [OCC_W-1:0] sib_occ = '0;
  logic [1:0]       priv_lvl = '0;
  logic             cfg_we = 1'b0;
  logic [13:0]      cfg_wdata = '0;
  logic [13:0]      cfg_rdata;
  logic             cnt_we = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic [CNT_W-1:0] cnt_value;
  logic             ovf;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    cmp_on  = 1'b0;
  bit    finished = 1'b0;
  int    wr_pct  = 0;

  always #4 clk = ~clk;

  pec_event_counter #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u0 (.*);

  // Reference model
  logic [13:0]      m_cfg;
  logic [CNT_W-1:0] m_cnt;
  bit               m_ovf, m_prev;

  always @(posedge clk) begin
    int  amt, inc, thr;
    bit  pok, q;
    logic [CNT_W:0] t;
    if (!rst_n) begin
      m_cfg = '0; m_cnt = '0; m_ovf = 0; m_prev = 0;
    end else begin
      inc = 0;
      thr = int'(m_cfg[7:0]);
      if (cfg_we) begin
        m_cfg = cfg_wdata; m_prev = 0;
      end else if (!m_cfg[13]) begin
        m_prev = 0;
      end else if (evt_valid) begin
        pok = (priv_lvl == 0) ? m_cfg[9] : m_cfg[8];
        amt = int'(evt_occ) + (m_cfg[12] ? int'(sib_occ) : 0);
        if (thr == 0) begin
          if (!m_cfg[11] && pok) inc = amt;
        end else begin
          q = pok && ((amt >= thr) != m_cfg[10]);
          if (m_cfg[11]) inc = (q && !m_prev) ? 1 : 0;
          else           inc = q ? 1 : 0;
          m_prev = q;
        end
      end
      if (cnt_we) begin
        m_cnt = cnt_wdata; m_ovf = 0;
      end else begin
        t = {1'b0, m_cnt} + (CNT_W+1)'(inc);
        m_cnt = t[CNT_W-1:0];
        if (t[CNT_W]) m_ovf = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      n_tests++;
      if (cnt_value !== m_cnt || ovf !== m_ovf || cfg_rdata !== m_cfg || evt_ready !== 1'b1) begin
        n_fail++;
        $display("FAIL %s: cnt=%h ovf=%0d cfg=%h rdy=%0d expected cnt=%h ovf=%0d cfg=%h rdy=1",
                 cur_req, cnt_value, ovf, cfg_rdata, evt_ready, m_cnt, m_ovf, m_cfg);
      end
    end
  end

  function automatic logic [13:0] mk(bit en, bit any, bit edg, bit inv, bit krn, bit usr, int thr);
    return {en, any, edg, inv, krn, usr, 8'(thr)};
  endfunction

  task automatic set_cfg(string req, logic [13:0] w);
    @(posedge clk); #1;
    cur_req = req;
    cfg_we = 1'b1; cfg_wdata = w;
    evt_valid = 1'b1; evt_occ = 8'd200;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic run(int n, int lo, int hi);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      evt_valid = ($urandom_range(0, 9) < 8);
      evt_occ   = 8'($urandom_range(lo, hi));
      sib_occ   = 8'($urandom_range(lo, hi));
      priv_lvl  = 2'($urandom_range(0, 3));
      cnt_we    = ($urandom_range(0, 99) < wr_pct);
      cnt_wdata = {16'h0, 32'($urandom)};
    end
    @(posedge clk); #1;
    cnt_we = 1'b0;
  endtask

  task automatic load_cnt(logic [CNT_W-1:0] v);
    @(posedge clk); #1;
    cnt_we = 1'b1; cnt_wdata = v;
    @(posedge clk); #1;
    cnt_we = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    n_tests++;
    if (cnt_value !== '0 || ovf !== 1'b0 || cfg_rdata !== '0) begin
      n_fail++;
      $display("FAIL R1: cnt=%h ovf=%0d cfg=%h expected 0 0 0", cnt_value, ovf, cfg_rdata);
    end
    cmp_on = 1'b1;
    cur_req = "R11"; run(20, 0, 255);                       // R11 disabled after reset
    set_cfg("R3", mk(1,0,0,1,1,1,0));  run(40, 0, 255);     // R3 raw, invert ignored
    set_cfg("R8", mk(1,1,0,0,1,1,0));  run(30, 0, 255);     // R8 raw, summed threads
    set_cfg("R2", mk(1,0,0,0,0,1,0));  run(40, 0, 50);      // R2 user only
    set_cfg("R2", mk(1,0,0,0,1,0,0));  run(40, 0, 50);      // R2 kernel only
    set_cfg("R4", mk(1,0,0,0,1,1,100)); run(60, 0, 200);    // R4 threshold
    set_cfg("R4", mk(1,0,0,0,1,1,255)); run(40, 240, 255);  // R4 max threshold
    set_cfg("R5", mk(1,0,0,1,1,1,100)); run(60, 0, 200);    // R5 invert
    set_cfg("R8", mk(1,1,0,0,1,1,200)); run(60, 50, 150);   // R8 sum vs threshold
    set_cfg("R6", mk(1,0,1,0,1,1,50)); run(80, 0, 100);     // R6 edge
    set_cfg("R6", mk(0,0,1,0,1,1,50)); run(10, 0, 100);     // R6 history clear
    set_cfg("R6", mk(1,0,1,1,1,0,50)); run(80, 0, 100);     // R6 edge + invert
    set_cfg("R7", mk(1,0,1,0,1,1,0));  run(30, 0, 255);     // R7 invalid
    set_cfg("R11", mk(0,1,0,0,1,1,0)); run(20, 0, 255);     // R11 disabled
    set_cfg("R9", mk(1,1,0,0,1,1,0));
    cur_req = "R9";
    load_cnt(48'hFFFF_FFFF_FF00); run(20, 100, 255);        // R9 wrap sets ovf
    run(10, 0, 255);                                        // R9 sticky
    cur_req = "R10";
    load_cnt(48'h0000_1234_5678);                           // R10 clears ovf
    wr_pct = 20; run(80, 0, 255);                           // R10 write beats increment
    set_cfg("R10", mk(1,0,0,0,1,1,30)); run(60, 0, 60);
    wr_pct = 0;
    @(posedge clk); #1;
    cmp_on = 1'b0;
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule